// File: doc/BRIEF.md
# Multiword Vector Compare and Highest-Word Locator

This engine works on long unsigned integers held in a word-addressed RAM with one read port. Each integer is a run of words, least significant first, named by the RAM address of its lowest word and a length in words. A start pulse launches one of two scans. A compare scan runs over two vectors from the top word down and reports whether the first is greater than, less than or equal to the second. A locate scan runs over one vector from the top word down and reports the RAM address of its highest nonzero word. On request it also reports the position of the highest set bit inside that word.

The engine issues one RAM read per cycle on a synchronous port whose data returns one cycle later. Address issue for the next word overlaps the return of the previous one. Mode, pointers and lengths are sampled only in the cycle that start is accepted. The result outputs hold their values until the next completion.

Top module: `vscan_engine`

## Requirements
- R1: During and straight after reset, busy, done, err and mem_rd_en are low, and cmp_flags, msw_status and ms_bit are zero.
- R2: After a compare (mode = 0), cmp_flags has exactly one bit set: bit 2 when vector A is greater than B, bit 1 when A is less than B, bit 0 when they are equal. Both are unsigned, with the word at the pointer address least significant.
- R3: In a compare, the shorter vector is treated as if zero-extended to the longer length. Two zero-length vectors compare equal.
- R4: After a locate (mode = 1) on a vector A with a nonzero word, msw_status[ADDR_W-1:0] holds a_ptr plus the index of the highest nonzero word, and every other msw_status bit is 0.
- R5: After a locate on a vector whose words are all zero, or whose length is zero, msw_status[15] is 1 and msw_status[ADDR_W-1:0] is 0.
- R6: After a locate with ms_one_en = 1, ms_bit holds the bit number of the highest set bit in the highest nonzero word. With ms_one_en = 0, or on an all-zero vector, ms_bit is 0.
- R7: Result outputs change only in the cycle done is high. A compare leaves msw_status and ms_bit unchanged, and a locate leaves cmp_flags unchanged.
- R8: If a_ptr bit 0 is set, or b_ptr bit 0 is set in compare mode, done rises in the cycle after start with err = 1. No RAM read is made and the result outputs are unchanged. In locate mode b_ptr is ignored. Any later error-free completion clears err.
- R9: A read is issued only while busy, at most one per cycle. No read touches a word at or beyond a vector's length, and the word read is used one cycle after mem_rd_en.
- R10: Counting clock edges after the edge that takes start, done rises after L edges. A compare with n = max(a_len, b_len) has L = 2(n-k)+1, where k is the highest index whose words differ, and L = 2n+1 when the vectors are equal. A locate has L = len-k+1 with k the index of the highest nonzero word, and L = len+1 when all words are zero. A zero-length scan has L = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken while not busy |
| mode | input | 1 | 0 = compare A with B, 1 = locate the highest word of A |
| ms_one_en | input | 1 | Also report the highest set bit (locate) |
| a_ptr | input | ADDR_W | Address of the lowest word of A |
| b_ptr | input | ADDR_W | Address of the lowest word of B |
| a_len | input | LEN_W | Length of A in words |
| b_len | input | LEN_W | Length of B in words |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_addr | output | ADDR_W | RAM read address |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completion rejected a misaligned pointer |
| cmp_flags | output | 3 | {A>B, A<B, A==B} |
| msw_status | output | 16 | Bit 15 all-zero flag, [ADDR_W-1:0] word address |
| ms_bit | output | log2(DATA_W) | Highest set bit in the located word |

## Verification
The bench builds the engine with 8-bit words, an 8-bit address and 3-bit lengths. These narrow values make every single-word value (all 256) reachable for the bit locator, and every length pair from 0 to 7 reachable for compare. Locate runs every length with every position of the highest nonzero word. The RAM words beyond each length are filled with nonzero data, so a read past the end would change the result. Exact latency is checked on every run, and that check is what pins down the early stop and the two-slot step per compared word.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

   typedef enum logic {
      SCAN_CMP = 1'b0,
      SCAN_LOC = 1'b1
   } scan_mode_e;

   localparam int STATUS_W      = 16;
   localparam int ZERO_FLAG_BIT = 15;

   localparam logic [2:0] FLAG_GT = 3'b100;
   localparam logic [2:0] FLAG_LT = 3'b010;
   localparam logic [2:0] FLAG_EQ = 3'b001;

endpackage

// File: rtl/vscan_issue.sv
// Picks the vector being fetched and forms its RAM address and range test.
module vscan_issue #(
   parameter int ADDR_W = 11,
   parameter int LEN_W  = 9
) (
   input  logic              locate,
   input  logic              phase_b,
   input  logic [LEN_W-1:0]  idx,
   input  logic [ADDR_W-1:0] a_ptr,
   input  logic [ADDR_W-1:0] b_ptr,
   input  logic [LEN_W-1:0]  a_len,
   input  logic [LEN_W-1:0]  b_len,
   output logic [ADDR_W-1:0] addr,
   output logic              in_range
);
   logic              sel_b;
   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  lim;

   always_comb begin
      sel_b    = !locate && phase_b;
      base     = sel_b ? b_ptr : a_ptr;
      lim      = sel_b ? b_len : a_len;
      addr     = base + ADDR_W'(idx);
      in_range = idx < lim;
   end
endmodule

// File: rtl/vscan_msb.sv
// Position of the highest set bit of a word (0 when the word is zero).
module vscan_msb #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word,
   output logic [IDX_W-1:0]  pos
);
   generate
      if (DATA_W == 1) begin : g_single
         assign pos = '0;
      end else begin : g_scan
         always_comb begin
            pos = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (word[i]) pos = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vscan_engine.sv
module vscan_engine
   import vscan_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 9,
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode,
   input  logic                ms_one_en,
   input  logic [ADDR_W-1:0]   a_ptr,
   input  logic [ADDR_W-1:0]   b_ptr,
   input  logic [LEN_W-1:0]    a_len,
   input  logic [LEN_W-1:0]    b_len,
   output logic                mem_rd_en,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [2:0]          cmp_flags,
   output logic [STATUS_W-1:0] msw_status,
   output logic [IDX_W-1:0]    ms_bit
);

   generate
      if (ADDR_W < 2 || ADDR_W > ZERO_FLAG_BIT) begin : g_bad_addr
         $error("vscan_engine: ADDR_W must lie in 2..15");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("vscan_engine: DATA_W must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("vscan_engine: LEN_W must be at least 1");
      end
   endgenerate

   typedef enum logic {ST_IDLE, ST_RUN} state_e;

   state_e              st_q;
   scan_mode_e          mode_q;
   logic                msone_q;
   logic [ADDR_W-1:0]   ap_q, bp_q;
   logic [LEN_W-1:0]    al_q, bl_q;
   logic [LEN_W-1:0]    idx_q;
   logic                phase_q, issuing_q;
   // return-stage tags for the word arriving from RAM
   logic                pv_q, pz_q, pb_q, plast_q;
   logic [LEN_W-1:0]    pidx_q;
   logic [DATA_W-1:0]   a_hold_q;
   logic                done_q, err_q;
   logic [2:0]          cmp_q;
   logic [STATUS_W-1:0] msw_q;
   logic [IDX_W-1:0]    msb_q;

   scan_mode_e          mode_in;
   logic                ptr_bad;
   logic [LEN_W-1:0]    n_start;
   logic [ADDR_W-1:0]   iss_addr;
   logic                iss_in_range;
   logic                iss_last;
   logic [DATA_W-1:0]   word_w;
   logic [IDX_W-1:0]    word_msb;
   logic [STATUS_W-1:0] hit_status;

   always_comb begin
      mode_in = scan_mode_e'(mode);
      ptr_bad = a_ptr[0] || (mode_in == SCAN_CMP && b_ptr[0]);
      n_start = (mode_in == SCAN_CMP && b_len > a_len) ? b_len : a_len;
   end

   vscan_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_issue (
      .locate   (mode_q == SCAN_LOC),
      .phase_b  (phase_q),
      .idx      (idx_q),
      .a_ptr    (ap_q),
      .b_ptr    (bp_q),
      .a_len    (al_q),
      .b_len    (bl_q),
      .addr     (iss_addr),
      .in_range (iss_in_range)
   );

   always_comb begin
      iss_last   = (idx_q == '0) && (mode_q == SCAN_LOC || phase_q);
      word_w     = pz_q ? '0 : mem_rdata;
      hit_status = '0;
      hit_status[ADDR_W-1:0] = ap_q + ADDR_W'(pidx_q);
   end

   vscan_msb #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_msb (
      .word (word_w),
      .pos  (word_msb)
   );

   assign mem_rd_en  = (st_q == ST_RUN) && issuing_q && iss_in_range;
   assign mem_addr   = iss_addr;
   assign busy       = (st_q == ST_RUN);
   assign done       = done_q;
   assign err        = err_q;
   assign cmp_flags  = cmp_q;
   assign msw_status = msw_q;
   assign ms_bit     = msb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         mode_q    <= SCAN_CMP;
         msone_q   <= 1'b0;
         ap_q      <= '0;
         bp_q      <= '0;
         al_q      <= '0;
         bl_q      <= '0;
         idx_q     <= '0;
         phase_q   <= 1'b0;
         issuing_q <= 1'b0;
         pv_q      <= 1'b0;
         pz_q      <= 1'b0;
         pb_q      <= 1'b0;
         plast_q   <= 1'b0;
         pidx_q    <= '0;
         a_hold_q  <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         cmp_q     <= '0;
         msw_q     <= '0;
         msb_q     <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  if (ptr_bad) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     mode_q  <= mode_in;
                     msone_q <= ms_one_en;
                     ap_q    <= a_ptr;
                     bp_q    <= b_ptr;
                     al_q    <= a_len;
                     bl_q    <= b_len;
                     phase_q <= 1'b0;
                     pv_q    <= 1'b0;
                     if (n_start == '0) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                        if (mode_in == SCAN_CMP) begin
                           cmp_q <= FLAG_EQ;
                        end else begin
                           msw_q <= STATUS_W'(1) << ZERO_FLAG_BIT;
                           msb_q <= '0;
                        end
                     end else begin
                        st_q      <= ST_RUN;
                        issuing_q <= 1'b1;
                        idx_q     <= n_start - LEN_W'(1);
                     end
                  end
               end
            end
            ST_RUN: begin
               // tag the read issued this cycle
               pv_q    <= issuing_q;
               pz_q    <= !iss_in_range;
               pb_q    <= phase_q;
               plast_q <= iss_last;
               pidx_q  <= idx_q;
               if (issuing_q) begin
                  if (mode_q == SCAN_CMP && !phase_q) begin
                     phase_q <= 1'b1;
                  end else begin
                     phase_q <= 1'b0;
                     if (idx_q == '0) issuing_q <= 1'b0;
                     else             idx_q     <= idx_q - LEN_W'(1);
                  end
               end
               // consume the word returned for last cycle's read
               if (pv_q) begin
                  if (mode_q == SCAN_CMP) begin
                     if (!pb_q) begin
                        a_hold_q <= word_w;
                     end else if (a_hold_q != word_w || plast_q) begin
                        cmp_q     <= (a_hold_q > word_w) ? FLAG_GT :
                                     (a_hold_q < word_w) ? FLAG_LT : FLAG_EQ;
                        st_q      <= ST_IDLE;
                        issuing_q <= 1'b0;
                        pv_q      <= 1'b0;
                        done_q    <= 1'b1;
                        err_q     <= 1'b0;
                     end
                  end else if (word_w != '0 || plast_q) begin
                     if (word_w != '0) begin
                        msw_q <= hit_status;
                        msb_q <= msone_q ? word_msb : '0;
                     end else begin
                        msw_q <= STATUS_W'(1) << ZERO_FLAG_BIT;
                        msb_q <= '0;
                     end
                     st_q      <= ST_IDLE;
                     issuing_q <= 1'b0;
                     pv_q      <= 1'b0;
                     done_q    <= 1'b1;
                     err_q     <= 1'b0;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vscan_chk.sv
module vscan_chk #(
   parameter int ADDR_W = 11,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mode,
   input logic [ADDR_W-1:0] a_ptr,
   input logic [ADDR_W-1:0] b_ptr,
   input logic              mem_rd_en,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [2:0]        cmp_flags,
   input logic [15:0]       msw_status,
   input logic [IDX_W-1:0]  ms_bit
);

   assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmp_flags));

   assert_zero_addr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      msw_status[15] |-> (msw_status[ADDR_W-1:0] == '0));

   assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($stable(cmp_flags) && $stable(msw_status) && $stable(ms_bit)));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_bad_a_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && a_ptr[0]) |=> (done && err && !busy));

   assert_bad_b_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !mode && b_ptr[0]) |=> (done && err));

   assert_read_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

endmodule

bind vscan_engine vscan_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_vscan_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .a_ptr      (a_ptr),
   .b_ptr      (b_ptr),
   .mem_rd_en  (mem_rd_en),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .cmp_flags  (cmp_flags),
   .msw_status (msw_status),
   .ms_bit     (ms_bit)
);

// File: tb/test_vscan_engine.sv
`timescale 1ns/1ps
module test_vscan_engine;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int LW = 3;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic          ms_one_en = 1'b0;
   logic [AW-1:0] a_ptr = '0, b_ptr = '0;
   logic [LW-1:0] a_len = '0, b_len = '0;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, err;
   logic [2:0]    cmp_flags;
   logic [15:0]   msw_status;
   logic [IW-1:0] ms_bit;

   logic [DW-1:0] mem [0:255];

   int checks = 0;
   int errors = 0;
   int bad_reads = 0;
   int nreads = 0;
   int viol = 0;
   int cur_ap = 0, cur_bp = 0, cur_al = 0, cur_bl = 0;
   logic cur_md = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   logic [2:0]  prev_flags = '0;
   logic [15:0] prev_msw = '0;
   logic [IW-1:0] prev_msb = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vscan_engine #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) i_vscan_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ms_one_en(ms_one_en),
      .a_ptr(a_ptr), .b_ptr(b_ptr), .a_len(a_len), .b_len(b_len),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .err(err), .cmp_flags(cmp_flags),
      .msw_status(msw_status), .ms_bit(ms_bit)
   );

   // one-cycle synchronous RAM
   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= mem[mem_addr];
         nreads++;
         if (!((int'(mem_addr) >= cur_ap && int'(mem_addr) < cur_ap + cur_al) ||
               (!cur_md && int'(mem_addr) >= cur_bp && int'(mem_addr) < cur_bp + cur_bl)))
            bad_reads++;
      end
   end

   // results may move only alongside done
   always @(negedge clk) begin
      if (rst_n && !done &&
          (cmp_flags != prev_flags || msw_status != prev_msw || ms_bit != prev_msb))
         viol++;
      prev_flags = cmp_flags;
      prev_msw   = msw_status;
      prev_msb   = ms_bit;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[23:16];
   endfunction

   function automatic int hibit(input int v);
      int r = 0;
      for (int i = 0; i < DW; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic run(input logic md, input logic ms, input int ap, input int bp,
                      input int al, input int bl, output int lat);
      @(negedge clk);
      cur_md = md; cur_ap = ap; cur_bp = bp; cur_al = al; cur_bl = bl;
      bad_reads = 0; nreads = 0; viol = 0;
      mode = md; ms_one_en = ms;
      a_ptr = AW'(ap); b_ptr = AW'(bp); a_len = LW'(al); b_len = LW'(bl);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(bad_reads == 0, "R9", "reads outside vector", bad_reads, 0);
      check(viol == 0, "R7", "result moved without done", viol, 0);
   endtask

   initial begin
      int lat;
      logic [2:0] f_before;
      logic [15:0] m_before;
      for (int i = 0; i < 256; i++) mem[i] = '0;

      repeat (3) @(negedge clk);
      check(!busy && !done && !err && !mem_rd_en, "R1", "control in reset",
            {busy, done, err, mem_rd_en}, 0);
      check(cmp_flags == 0 && msw_status == 0 && ms_bit == 0, "R1", "results in reset",
            {cmp_flags, msw_status, ms_bit}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && cmp_flags == 0 && msw_status == 0, "R1", "after release",
            {busy, done, cmp_flags, msw_status}, 0);

      // R6: every single-word value
      for (int v = 0; v < 256; v++) begin
         mem[8'h20] = DW'(v);
         mem[8'h21] = 8'hFF;
         run(1'b1, 1'b1, 8'h20, 0, 1, 0, lat);
         if (v == 0) begin
            check(msw_status == 16'h8000, "R5", "zero word status", msw_status, 16'h8000);
            check(ms_bit == 0, "R6", "zero word bit", ms_bit, 0);
         end else begin
            check(msw_status == 16'h0020, "R4", "single word status", msw_status, 16'h0020);
            check(int'(ms_bit) == hibit(v), "R6", "highest bit", ms_bit, hibit(v));
         end
         check(lat == 2, "R10", "single word latency", lat, 2);
      end
      for (int v = 1; v < 256; v += 17) begin
         mem[8'h20] = DW'(v);
         run(1'b1, 1'b0, 8'h20, 0, 1, 0, lat);
         check(ms_bit == 0, "R6", "bit report off", ms_bit, 0);
      end

      // R4 R5 R10: every length and top-word position
      for (int len = 0; len < 8; len++) begin
         for (int k = -1; k < len; k++) begin
            int ap = 8'h30 + 2 * len;
            int el;
            for (int i = 0; i < 8; i++) begin
               if (i >= len)     mem[ap + i] = rnd() | 8'h01;
               else if (i > k)   mem[ap + i] = '0;
               else if (i == k)  mem[ap + i] = rnd() | 8'h10;
               else              mem[ap + i] = rnd();
            end
            f_before = cmp_flags;
            run(1'b1, 1'b1, ap, 8'h81, len, 0, lat);
            if (k < 0) begin
               check(msw_status == 16'h8000, "R5", "all-zero status", msw_status, 16'h8000);
               check(ms_bit == 0, "R6", "all-zero bit", ms_bit, 0);
            end else begin
               check(msw_status == 16'(ap + k), "R4", "top word address", msw_status, ap + k);
               check(int'(ms_bit) == hibit(int'(mem[ap + k])), "R6", "top word bit",
                     ms_bit, hibit(int'(mem[ap + k])));
            end
            check(!err, "R8", "b_ptr ignored in locate", err, 0);
            check(cmp_flags == f_before, "R7", "locate kept flags", cmp_flags, f_before);
            el = (len == 0) ? 0 : ((k < 0) ? len + 1 : len - k + 1);
            check(lat == el, "R10", "locate latency", lat, el);
         end
      end

      // R2 R3 R10: every length pair, four data styles
      for (int al = 0; al < 8; al++) begin
         for (int bl = 0; bl < 8; bl++) begin
            for (int vr = 0; vr < 4; vr++) begin
               logic [63:0] av, bv;
               logic [2:0] ef;
               int n, kd, el;
               for (int i = 0; i < 8; i++) begin
                  logic [DW-1:0] x;
                  x = rnd();
                  mem[8'h40 + i] = rnd();
                  mem[8'h60 + i] = rnd();
                  if (vr == 1 || vr == 2) begin
                     if (i < al) mem[8'h40 + i] = (i < bl) ? x : '0;
                     if (i < bl) mem[8'h60 + i] = (i < al) ? x : '0;
                  end
                  if (vr == 3 && i < al) mem[8'h40 + i] = '0;
               end
               n = (al > bl) ? al : bl;
               if (vr == 2 && n > 0) begin
                  int j = int'(seed[10:8]) % n;
                  if (j < al) mem[8'h40 + j] ^= 8'h01;
                  else        mem[8'h60 + j] ^= 8'h01;
               end
               av = '0; bv = '0;
               for (int i = 0; i < 8; i++) begin
                  if (i < al) av |= 64'(mem[8'h40 + i]) << (DW * i);
                  if (i < bl) bv |= 64'(mem[8'h60 + i]) << (DW * i);
               end
               ef = (av > bv) ? 3'b100 : (av < bv) ? 3'b010 : 3'b001;
               kd = -1;
               for (int i = n - 1; i >= 0; i--) begin
                  logic [DW-1:0] wa, wb;
                  wa = (i < al) ? mem[8'h40 + i] : '0;
                  wb = (i < bl) ? mem[8'h60 + i] : '0;
                  if (kd < 0 && wa != wb) kd = i;
               end
               el = (n == 0) ? 0 : ((kd < 0) ? 2 * n + 1 : 2 * (n - kd) + 1);
               m_before = msw_status;
               run(1'b0, 1'b0, 8'h40, 8'h60, al, bl, lat);
               check(cmp_flags == ef, (al != bl) ? "R3" : "R2", "compare flags", cmp_flags, ef);
               check(lat == el, "R10", "compare latency", lat, el);
               check(msw_status == m_before, "R7", "compare kept status", msw_status, m_before);
            end
         end
      end

      // R8: misaligned pointers
      f_before = cmp_flags;
      m_before = msw_status;
      run(1'b0, 1'b0, 8'h41, 8'h60, 3, 3, lat);
      check(err && lat == 0, "R8", "odd A in compare", {err, 8'(lat)}, 9'h100);
      check(nreads == 0, "R8", "no read on error", nreads, 0);
      check(cmp_flags == f_before, "R8", "flags kept", cmp_flags, f_before);
      run(1'b0, 1'b0, 8'h40, 8'h61, 3, 3, lat);
      check(err && lat == 0, "R8", "odd B in compare", {err, 8'(lat)}, 9'h100);
      check(nreads == 0 && cmp_flags == f_before, "R8", "odd B untouched", nreads, 0);
      run(1'b1, 1'b1, 8'h33, 8'h60, 4, 0, lat);
      check(err && lat == 0, "R8", "odd A in locate", {err, 8'(lat)}, 9'h100);
      check(msw_status == m_before && nreads == 0, "R8", "status kept", msw_status, m_before);
      mem[8'h40] = 8'h05; mem[8'h60] = 8'h05;
      run(1'b0, 1'b0, 8'h40, 8'h60, 1, 1, lat);
      check(!err, "R8", "error cleared", err, 0);
      check(cmp_flags == 3'b001, "R2", "equal after error", cmp_flags, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule